// File: doc/BRIEF.md
# Transfer request staging queue

This block moves DMA transfer requests (TRs) through three holding places. A TR is first written into a single programming slot. From there it is admitted into a four-entry destination queue and, in the same clock, loaded into the source stage, which stays busy until the source side reports that it is finished. Each TR leaves the destination queue when the destination side reports that the head entry is complete. A separate counter tracks how many write commands are still waiting for their write status. The state of all of these is packed into a read-only 32-bit status word.

Admission follows the queue's fill level. An empty queue takes the slot's TR on the next clock whatever the source stage is doing. A partly filled queue takes it only while the source stage is idle. A full queue takes nothing until its head entry completes. The programming side sees a ready signal that is high only while the slot is empty. The destination side sees the head TR and a valid flag.

Top module: `tr_stage_queue`

## Requirements
- R1: After reset the status word reads 0x00000100, `prog_ready_o` is 1, `head_valid_o` is 0, and the occupancy, head offset and write count are all zero.
- R2: A TR write (`tr_wr_i`) is taken into the slot only while `prog_ready_o` is 1. Status bit 0 is 1 while the slot holds a TR that has not moved on. A write made while the slot is held is ignored, and the held payload is kept.
- R3: While the destination queue is empty, a held TR enters it on the next clock edge, even when the source stage is busy.
- R4: While the destination queue holds 1 to 3 TRs, a held TR enters it only on an edge at which the source stage was idle (status bit 1 = 0).
- R5: While the destination queue holds 4 TRs, no TR enters it. This includes the edge at which the head completes. Entry resumes on the following edge.
- R6: Status bits 6:4 give the destination occupancy (0 to 4; 5 to 7 never occur). An entry and a head completion on the same edge leave it unchanged. A completion while the queue is empty is ignored.
- R7: Status bits 13:12 give the head offset, which advances by one modulo 4 on every accepted completion. `head_tr_o` is the TR at that offset, and TRs leave in the order they were written.
- R8: Status bit 1 is 1 from the edge at which a TR enters the queue until a `src_done_i` edge. In the idle state `src_tr_o` still holds the last TR loaded, and `src_done_i` while idle is ignored.
- R9: Status bit 2 is 1 while the outstanding-write count is non-zero. The count rises on `wr_issue_i`, falls on `wr_status_i`, and is unchanged when both arrive together. It does not fall below 0 and does not rise above 2^WCNT_W-1.
- R10: Status bit 8 always reads 1. Bits 3, 7, 11:9 and 31:14 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tr_wr_i | input | 1 | TR write strobe |
| tr_data_i | input | TR_W | TR payload |
| prog_ready_o | output | 1 | Programming slot empty, a write is accepted |
| src_done_i | input | 1 | Source stage finished its TR |
| dst_done_i | input | 1 | Head TR of destination queue completed |
| wr_issue_i | input | 1 | A write command was issued |
| wr_status_i | input | 1 | A write status was received |
| status_o | output | 32 | Read-only status word |
| head_valid_o | output | 1 | Destination queue non-empty |
| head_tr_o | output | TR_W | TR at the head of the destination queue |
| src_tr_o | output | TR_W | TR held by the source stage |

## Verification
The bench builds the block with its defaults: TR_W = 16, DQ_DEPTH = 4 and WCNT_W = 4. A queue depth of 4 makes the full-queue stall and the wrap of the 2-bit head offset reachable within a few dozen cycles. A 4-bit write counter lets twenty issues push it into saturation at 15, so both the ceiling and the floor of the count can be observed through bit 2. A scoreboard follows every accepted TR to its exit at the head, and the status word is compared with hand-derived values after each edge.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_BUSY = 1'b1
    } src_state_e;

    localparam int unsigned STAT_W = 32;

endpackage

// File: rtl/tsq_prog_slot.sv
module tsq_prog_slot
    import tsq_pkg::*;
#(
    parameter int unsigned TR_W = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_i,
    input  logic [TR_W-1:0] data_i,
    input  logic            take_i,
    output logic            ready_o,
    output logic            held_o,
    output logic [TR_W-1:0] tr_o
);

    slot_state_e state_q, state_d;
    logic [TR_W-1:0] tr_q;

    // next-state logic: EMPTY --write--> HELD --take--> EMPTY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (wr_i)   state_d = SLOT_HELD;
            SLOT_HELD:  if (take_i) state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SLOT_EMPTY;
            tr_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SLOT_EMPTY && wr_i) tr_q <= data_i;
        end
    end

    always_comb begin
        ready_o = (state_q == SLOT_EMPTY);
        held_o  = (state_q == SLOT_HELD);
        tr_o    = tr_q;
    end

endmodule

// File: rtl/tsq_src_stage.sv
module tsq_src_stage
    import tsq_pkg::*;
#(
    parameter int unsigned TR_W = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            load_i,
    input  logic [TR_W-1:0] data_i,
    input  logic            done_i,
    output logic            busy_o,
    output logic [TR_W-1:0] tr_o
);

    src_state_e state_q, state_d;
    logic [TR_W-1:0] tr_q;

    // IDLE --load--> BUSY; BUSY --load--> BUSY (reload); BUSY --done--> IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: if (load_i) state_d = SRC_BUSY;
            SRC_BUSY: begin
                if (load_i)      state_d = SRC_BUSY;
                else if (done_i) state_d = SRC_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SRC_IDLE;
            tr_q    <= '0;
        end else begin
            state_q <= state_d;
            if (load_i) tr_q <= data_i;
        end
    end

    always_comb begin
        busy_o = (state_q == SRC_BUSY);
        tr_o   = tr_q;
    end

endmodule

// File: rtl/tsq_dst_fifo.sv
module tsq_dst_fifo #(
    parameter int unsigned TR_W     = 16,
    parameter int unsigned DQ_DEPTH = 4,
    localparam int unsigned PTR_W   = (DQ_DEPTH > 1) ? $clog2(DQ_DEPTH) : 1,
    localparam int unsigned CNT_W   = $clog2(DQ_DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [TR_W-1:0]  data_i,
    input  logic             pop_i,
    output logic [CNT_W-1:0] count_o,
    output logic [PTR_W-1:0] head_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [TR_W-1:0]  head_tr_o
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DQ_DEPTH);

    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail;
    logic             pop_ok;
    logic [TR_W-1:0]  mem_q [DQ_DEPTH];

    assign pop_ok = pop_i && (cnt_q != '0);
    assign tail   = head_q + PTR_W'(cnt_q);

    for (genvar e = 0; e < DQ_DEPTH; e++) begin : g_entry
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                            mem_q[e] <= '0;
            else if (push_i && tail == PTR_W'(e))   mem_q[e] <= data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            head_q <= '0;
        end else begin
            unique case ({push_i, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (pop_ok) head_q <= head_q + 1'b1;
        end
    end

    always_comb begin
        count_o   = cnt_q;
        head_o    = head_q;
        empty_o   = (cnt_q == '0);
        full_o    = (cnt_q == CNT_FULL);
        head_tr_o = mem_q[head_q];
    end

endmodule

// File: rtl/tsq_wr_tracker.sv
module tsq_wr_tracker #(
    parameter int unsigned WCNT_W = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic issue_i,
    input  logic status_i,
    output logic pending_o
);

    localparam logic [WCNT_W-1:0] CNT_MAX = '1;

    logic [WCNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            unique case ({issue_i, status_i})
                2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                2'b01:   if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign pending_o = (cnt_q != '0);

endmodule

// File: rtl/tr_stage_queue.sv
module tr_stage_queue
    import tsq_pkg::*;
#(
    parameter int unsigned TR_W     = 16,
    parameter int unsigned DQ_DEPTH = 4,
    parameter int unsigned WCNT_W   = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tr_wr_i,
    input  logic [TR_W-1:0] tr_data_i,
    output logic            prog_ready_o,
    input  logic            src_done_i,
    input  logic            dst_done_i,
    input  logic            wr_issue_i,
    input  logic            wr_status_i,
    output logic [31:0]     status_o,
    output logic            head_valid_o,
    output logic [TR_W-1:0] head_tr_o,
    output logic [TR_W-1:0] src_tr_o
);

    localparam int unsigned PTR_W = (DQ_DEPTH > 1) ? $clog2(DQ_DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DQ_DEPTH + 1);

    logic             slot_held;
    logic [TR_W-1:0]  slot_tr;
    logic             admit;
    logic             src_busy;
    logic [CNT_W-1:0] dq_cnt;
    logic [PTR_W-1:0] dq_head;
    logic             dq_empty;
    logic             dq_full;
    logic             wr_pending;

    // admission rule uses the registered fill level and source state
    assign admit = slot_held && (dq_empty || (!dq_full && !src_busy));

    tsq_prog_slot #(.TR_W(TR_W)) u_slot (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (tr_wr_i),
        .data_i  (tr_data_i),
        .take_i  (admit),
        .ready_o (prog_ready_o),
        .held_o  (slot_held),
        .tr_o    (slot_tr)
    );

    tsq_src_stage #(.TR_W(TR_W)) u_src (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (admit),
        .data_i (slot_tr),
        .done_i (src_done_i),
        .busy_o (src_busy),
        .tr_o   (src_tr_o)
    );

    tsq_dst_fifo #(.TR_W(TR_W), .DQ_DEPTH(DQ_DEPTH)) u_dq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .push_i    (admit),
        .data_i    (slot_tr),
        .pop_i     (dst_done_i),
        .count_o   (dq_cnt),
        .head_o    (dq_head),
        .empty_o   (dq_empty),
        .full_o    (dq_full),
        .head_tr_o (head_tr_o)
    );

    tsq_wr_tracker #(.WCNT_W(WCNT_W)) u_wr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .issue_i   (wr_issue_i),
        .status_i  (wr_status_i),
        .pending_o (wr_pending)
    );

    always_comb begin
        status_o        = '0;
        status_o[0]     = slot_held;
        status_o[1]     = src_busy;
        status_o[2]     = wr_pending;
        status_o[6:4]   = 3'(dq_cnt);
        status_o[8]     = 1'b1;
        status_o[13:12] = 2'(dq_head);
        head_valid_o    = !dq_empty;
    end

endmodule

// File: rtl/tsq_checker.sv
module tsq_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        tr_wr_i,
    input logic        prog_ready_o,
    input logic        src_done_i,
    input logic        dst_done_i,
    input logic        wr_issue_i,
    input logic        wr_status_i,
    input logic [31:0] status_o
);

    logic       held, busy, pend;
    logic [2:0] occ;
    logic [1:0] hptr;

    assign held = status_o[0];
    assign busy = status_o[1];
    assign pend = status_o[2];
    assign occ  = status_o[6:4];
    assign hptr = status_o[13:12];

    // R2: accepted write shows up as a held slot
    assert_wr_taken_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prog_ready_o && tr_wr_i) |=> held);

    // R3: empty queue admits on the next edge
    assert_empty_admit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (held && occ == 3'd0) |=> (!held && occ == 3'd1 && busy));

    // R4: partly filled queue with a busy source keeps the slot held
    assert_busy_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (held && occ != 3'd0 && occ != 3'd4 && busy) |=> held);

    // R5: full queue never grows; a completion drops it to three
    assert_full_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (occ == 3'd4 && dst_done_i) |=> (occ == 3'd3 && $stable(held)));

    // R6: occupancy stays in its legal range
    assert_occ_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        occ <= 3'd4);

    // R7: head offset advances by one on an accepted completion
    assert_head_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dst_done_i && occ != 3'd0) |=> hptr == $past(hptr) + 2'd1);

    // R8: source done with no admission makes the stage idle
    assert_src_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_done_i && !held) |=> !busy);

    // R9: lone status receipt never raises the pending flag
    assert_ws_floor_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_status_i && !wr_issue_i && !pend) |=> !pend);

    // R10: fixed bits of the status word
    assert_fixed_bits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[8] && status_o[31:14] == '0 && status_o[11:9] == '0
         && !status_o[7] && !status_o[3]));

endmodule

bind tr_stage_queue tsq_checker u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tr_wr_i      (tr_wr_i),
    .prog_ready_o (prog_ready_o),
    .src_done_i   (src_done_i),
    .dst_done_i   (dst_done_i),
    .wr_issue_i   (wr_issue_i),
    .wr_status_i  (wr_status_i),
    .status_o     (status_o)
);

// File: tb/tr_stage_queue_tb.sv
module tr_stage_queue_tb_top;

    localparam int unsigned TR_W = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            tr_wr;
    logic [TR_W-1:0] tr_data;
    logic            prog_ready;
    logic            src_done;
    logic            dst_done;
    logic            wr_issue;
    logic            wr_status;
    logic [31:0]     status;
    logic            head_valid;
    logic [TR_W-1:0] head_tr;
    logic [TR_W-1:0] src_tr;

    int n_chk  = 0;
    int n_fail = 0;
    logic [TR_W-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    tr_stage_queue #(.TR_W(TR_W), .DQ_DEPTH(4), .WCNT_W(4)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tr_wr_i      (tr_wr),
        .tr_data_i    (tr_data),
        .prog_ready_o (prog_ready),
        .src_done_i   (src_done),
        .dst_done_i   (dst_done),
        .wr_issue_i   (wr_issue),
        .wr_status_i  (wr_status),
        .status_o     (status),
        .head_valid_o (head_valid),
        .head_tr_o    (head_tr),
        .src_tr_o     (src_tr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_st(input string req, input logic [31:0] exp);
        chk(status == exp, req, status, exp);
    endtask

    // one cycle of stimulus; the driver side of the scoreboard
    task automatic cyc(input bit wr, input logic [TR_W-1:0] d, input bit sd,
                       input bit hd, input bit wi, input bit ws);
        tr_wr = wr; tr_data = d; src_done = sd; dst_done = hd;
        wr_issue = wi; wr_status = ws;
        if (wr && prog_ready) exp_q.push_back(d);
        @(posedge clk); #1;
        tr_wr = 1'b0; tr_data = '0; src_done = 1'b0; dst_done = 1'b0;
        wr_issue = 1'b0; wr_status = 1'b0;
    endtask

    // monitor side of the scoreboard: compare each departing head (R7)
    always @(negedge clk) begin
        if (rst_n && dst_done && head_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected head", 32'(head_tr), 32'hFFFF_FFFF);
            end else begin
                logic [TR_W-1:0] e;
                e = exp_q.pop_front();
                chk(head_tr == e, "R7 head order", 32'(head_tr), 32'(e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tr_wr = 1'b0; tr_data = '0; src_done = 1'b0;
        dst_done = 1'b0; wr_issue = 1'b0; wr_status = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk_st("R1 reset status", 32'h0000_0100);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk_st("R1 status after release", 32'h0000_0100);
        chk(prog_ready == 1'b1, "R1 ready", 32'(prog_ready), 32'd1);
        chk(head_valid == 1'b0, "R1 head_valid", 32'(head_valid), 32'd0);

        // R2/R3: write A, then it enters the empty queue
        cyc(1, 16'hA001, 0, 0, 0, 0);
        chk_st("R2 slot held", 32'h0000_0101);
        chk(prog_ready == 1'b0, "R2 ready low while held", 32'(prog_ready), 32'd0);
        cyc(0, 0, 0, 0, 0, 0);
        chk_st("R3 empty queue admit", 32'h0000_0112);
        chk(head_tr == 16'hA001, "R7 head after first admit", 32'(head_tr), 32'hA001);

        // R4: non-empty queue, busy source blocks B
        cyc(1, 16'hB002, 0, 0, 0, 0);
        chk_st("R4 B held", 32'h0000_0113);
        cyc(0, 0, 0, 0, 0, 0);
        chk_st("R4 blocked while source busy", 32'h0000_0113);
        cyc(0, 0, 1, 0, 0, 0);
        chk_st("R8 source idle, B still held", 32'h0000_0111);
        chk(src_tr == 16'hA001, "R8 idle stage keeps last TR", 32'(src_tr), 32'hA001);
        cyc(0, 0, 0, 0, 0, 0);
        chk_st("R4 admit with idle source", 32'h0000_0122);

        // fill to four
        cyc(0, 0, 1, 0, 0, 0);
        cyc(1, 16'hC003, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk_st("R6 occupancy three", 32'h0000_0132);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(1, 16'hD004, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        chk_st("R6 occupancy four, idle", 32'h0000_0140);

        // R5: full queue blocks E; R2: write while held ignored
        cyc(1, 16'hE005, 0, 0, 0, 0);
        chk_st("R5 E held at full", 32'h0000_0141);
        cyc(1, 16'h0BAD, 0, 0, 0, 0);
        chk_st("R5 full still blocks", 32'h0000_0141);
        cyc(0, 0, 0, 1, 0, 0);
        chk_st("R5 no admit on completion edge", 32'h0000_1131);
        cyc(0, 0, 0, 0, 0, 0);
        chk_st("R5 admit after leaving full", 32'h0000_1142);

        // drain all four; head offset wraps (R7)
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        chk_st("R7 head offset wrapped to 0", 32'h0000_0112);
        cyc(0, 0, 0, 1, 0, 0);
        chk_st("R7 drained, offset 1", 32'h0000_1102);
        cyc(0, 0, 1, 0, 0, 0);
        chk_st("R8 source idle after done", 32'h0000_1100);
        chk(src_tr == 16'hE005, "R2 held payload kept over ignored write", 32'(src_tr), 32'hE005);

        // R6: simultaneous entry and completion
        cyc(1, 16'hF006, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk_st("R3 F admitted", 32'h0000_1112);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(1, 16'h1007, 0, 0, 0, 0);
        chk_st("R4 G held", 32'h0000_1111);
        cyc(0, 0, 0, 1, 0, 0);
        chk_st("R6 entry plus completion keeps count", 32'h0000_2112);
        chk(head_tr == 16'h1007, "R7 G at head", 32'(head_tr), 32'h1007);

        // R6: completion on empty queue ignored; R8: done while idle ignored
        cyc(0, 0, 1, 1, 0, 0);
        chk_st("R6 drained", 32'h0000_3100);
        cyc(0, 0, 0, 1, 0, 0);
        chk_st("R6 completion on empty ignored", 32'h0000_3100);
        cyc(0, 0, 1, 0, 0, 0);
        chk_st("R8 done while idle ignored", 32'h0000_3100);
        chk(src_tr == 16'h1007, "R8 last TR kept", 32'(src_tr), 32'h1007);

        // R9: write tracking
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0);
        chk_st("R9 pending after issues", 32'h0000_3104);
        cyc(0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 0, 1);
        chk_st("R9 one still pending", 32'h0000_3104);
        cyc(0, 0, 0, 0, 0, 1);
        chk_st("R9 all status returned", 32'h0000_3100);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);
        chk_st("R9 no underflow at zero", 32'h0000_3100);
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 14; i++) cyc(0, 0, 0, 0, 0, 1);
        chk_st("R9 saturated count minus 14", 32'h0000_3104);
        cyc(0, 0, 0, 0, 0, 1);
        chk_st("R9 saturation at 15", 32'h0000_3100);

        chk(status[8] && status[31:14] == '0 && status[11:9] == '0 && !status[7] && !status[3],
            "R10 fixed bits", status, 32'h0000_0100);
        chk(exp_q.size() == 0, "R7 scoreboard empty", 32'(exp_q.size()), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule